// File: doc/BRIEF.md
# RGB565 to Component Video Colour Converter

This block turns 16-bit RGB565 pixels into three 8-bit codes for a component-video DAC: one luma code (Y) and two colour-difference codes (Pb, Pr). Each code is a fixed signed matrix row applied to the pixel's expanded channels, plus an offset. Every matrix entry is first multiplied by a global output gain and divided by 128, so one input sets the output amplitude of all three channels together.

A video timing generator outside the block sends a pixel with a valid flag during active video. During porches and sync it raises the level-select input instead, and picks blank, negative sync or positive sync. The block puts the same level on all three outputs. The sync amplitude follows the same gain as the pixels. All results appear two clock cycles after the input, with an output valid flag.

Top module: `rgb565_ypbpr_conv`

## Requirements
- R1: The pixel input carries red in bits 15:11, green in bits 10:5 and blue in bits 4:0. Each channel is widened to 8 bits by repeating its top bits below it: red and blue as {c[4:0], c[4:2]}, green as {c[5:0], c[5:4]}.
- R2: The luma code uses the row (27, 92, 9) for (R, G, B) and has an offset of 80.
- R3: The Pb code uses the row (-15, -49, 64) and has an offset of 128.
- R4: The Pr code uses the row (64, -58, -6) and has an offset of 128.
- R5: Each matrix entry is replaced by entry × gain / 128, with the quotient truncated toward zero and held as a signed 8-bit value. A gain above 128 acts as 128, and a gain of 0 gives the offsets alone.
- R6: Each code is the sum of the three products, shifted right by 7 with the sign kept (rounding toward minus infinity), then the offset is added and the result is clamped to 0..255.
- R7: When pix_valid or lvl_sel is high at a rising edge, out_valid is high exactly two rising edges later, and the codes are updated in that same cycle.
- R8: With lvl_sel high, all three outputs carry the same level. Let m = 105 × gain / 128, truncated. lvl_kind 2'b00 gives 0, 2'b01 gives (−m) mod 256, 2'b10 gives m, and 2'b11 gives 0.
- R9: When lvl_sel and pix_valid are both high, the level is output and the pixel is discarded.
- R10: A new gain value applies to pixels and levels presented from the cycle after the gain change onward. Anything presented in the cycle of the change, or earlier, uses the old gain.
- R11: In a cycle where neither input was accepted two edges earlier, out_valid is low and the three codes keep their previous values.
- R12: A synchronous active-low reset clears out_valid and all codes to 0 and loads the coefficients for a gain of 60. A pixel presented in the first cycle after reset is converted with gain 60.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| gain | input | 8 | Output gain, 0..128 (larger values clamp to 128) |
| pix_valid | input | 1 | Pixel present on pix_rgb |
| pix_rgb | input | 16 | RGB565 pixel |
| lvl_sel | input | 1 | Output a blank/sync level instead of a pixel |
| lvl_kind | input | 2 | Level choice: 00 blank, 01 negative sync, 10 positive sync, 11 blank |
| out_valid | output | 1 | Codes updated this cycle |
| y_code | output | 8 | Luma DAC code |
| pb_code | output | 8 | Pb DAC code |
| pr_code | output | 8 | Pr DAC code |

## Verification
The bench builds the block with its default parameters: 8-bit gain and codes, a reset gain of 60, a gain ceiling of 128 and offsets of 80 and 128. At a gain of 128 the luma sum passes 255 and the Pr sum reaches −128, so both clamps can be exercised. At a gain of 60 several scaled entries are negative non-integers, which separates truncation toward zero from floor division. A gain input wider than the ceiling allows the clamp to be tested with a gain of 200. Single-bit channel patterns show whether the widening repeats the top bits or fills with zeros.

// File: rtl/ycc_pkg.sv
// Shared types and constants for the RGB565 to YPbPr converter.
// Assumes row order Y, Pb, Pr and column order R, G, B throughout.
package ycc_pkg;

    typedef logic signed [7:0] coef_t;

    typedef enum logic [1:0] {
        LVL_BLANK    = 2'b00,
        LVL_SYNC_NEG = 2'b01,
        LVL_SYNC_POS = 2'b10,
        LVL_SPARE    = 2'b11
    } lvl_kind_e;

    localparam int NROW      = 3;
    localparam int NCOL      = 3;
    localparam int SYNC_BASE = 105;

    // Unscaled matrix entry for a given row and column.
    function automatic int base_coef(input int row, input int col);
        int t [NROW][NCOL];
        t[0][0] = 27;  t[0][1] = 92;  t[0][2] = 9;
        t[1][0] = -15; t[1][1] = -49; t[1][2] = 64;
        t[2][0] = 64;  t[2][1] = -58; t[2][2] = -6;
        return t[row][col];
    endfunction

    // Entry times gain divided by 128, truncated toward zero.
    function automatic coef_t scale_coef(input int c, input int s);
        int p;
        p = c * s;
        return coef_t'(p / 128);
    endfunction

endpackage

// File: rtl/ycc_coef_bank.sv
// Holds the gain-scaled matrix entries and the sync-level magnitude.
// Assumes the gain is a plain unsigned value; values above GAIN_MAX clamp.
// The registers reload every cycle, so a gain change applies one cycle later.
module ycc_coef_bank
    import ycc_pkg::*;
#(
    parameter int GAIN_W   = 8,
    parameter int CODE_W   = 8,
    parameter int DEF_GAIN = 60,
    parameter int GAIN_MAX = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GAIN_W-1:0] gain_i,
    output coef_t             coef_o [NROW][NCOL],
    output logic [CODE_W-1:0] lvl_mag_o
);

    logic [GAIN_W-1:0] gain_eff;
    coef_t             coef_d [NROW][NCOL];
    logic [CODE_W-1:0] mag_d;
    logic              armed_q;

    // Clamp the gain to its ceiling.
    always_comb begin
        gain_eff = (gain_i > GAIN_W'(GAIN_MAX)) ? GAIN_W'(GAIN_MAX) : gain_i;
    end

    // Scale every matrix entry and the sync magnitude by the clamped gain.
    always_comb begin
        for (int r = 0; r < NROW; r++) begin
            for (int c = 0; c < NCOL; c++) begin
                coef_d[r][c] = scale_coef(base_coef(r, c), int'(gain_eff));
            end
        end
        mag_d = CODE_W'((SYNC_BASE * int'(gain_eff)) / 128);
    end

    // Register the scaled set; reset loads the default-gain set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NROW; r++) begin
                for (int c = 0; c < NCOL; c++) begin
                    coef_o[r][c] <= scale_coef(base_coef(r, c), DEF_GAIN);
                end
            end
            lvl_mag_o <= CODE_W'((SYNC_BASE * DEF_GAIN) / 128);
        end else begin
            coef_o    <= coef_d;
            lvl_mag_o <= mag_d;
        end
    end

    // Marks that at least one reload from the gain input has happened.
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    // R5
    zero_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(gain_i) == '0) |->
        (coef_o[0][0] == 0 && coef_o[1][2] == 0 && coef_o[2][1] == 0 && lvl_mag_o == '0));

    // R5
    gain_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(gain_i) >= GAIN_W'(GAIN_MAX)) |->
        (coef_o[0][1] == 92 && coef_o[2][1] == -58 && lvl_mag_o == CODE_W'(SYNC_BASE)));

endmodule

// File: rtl/ycc_row_mac.sv
// One matrix row: three products summed and registered (pipeline stage 1),
// then a sign-keeping shift by 7, an offset and a clamp (combinational output).
// Assumes the channels are already widened to 8 bits unsigned.
module ycc_row_mac
    import ycc_pkg::*;
#(
    parameter int CODE_W = 8,
    parameter int OFS    = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [7:0]        ch_i   [NCOL],
    input  coef_t             coef_i [NCOL],
    output logic [CODE_W-1:0] code_o
);

    localparam int SUM_W    = CODE_W + 11;
    localparam int CODE_MAX = (1 << CODE_W) - 1;

    logic signed [SUM_W-1:0] px [NCOL];
    logic signed [SUM_W-1:0] cf [NCOL];
    logic signed [SUM_W-1:0] acc_d;
    logic signed [SUM_W-1:0] sum_q;
    logic signed [SUM_W-1:0] biased;

    // Sign-extend both operands to the accumulator width and sum the products.
    always_comb begin
        acc_d = '0;
        for (int k = 0; k < NCOL; k++) begin
            px[k] = SUM_W'($signed({1'b0, ch_i[k]}));
            cf[k] = SUM_W'(coef_i[k]);
            acc_d = acc_d + px[k] * cf[k];
        end
    end

    // Stage 1 register: capture the sum for an accepted pixel.
    always_ff @(posedge clk) begin
        if (!rst_n)      sum_q <= '0;
        else if (load_i) sum_q <= acc_d;
    end

    // Shift with sign kept, add the offset, clamp to the code range.
    always_comb begin
        biased = (sum_q >>> 7) + $signed(SUM_W'(OFS));
        if (biased < 0)
            code_o = '0;
        else if (biased > $signed(SUM_W'(CODE_MAX)))
            code_o = CODE_W'(CODE_MAX);
        else
            code_o = CODE_W'(biased);
    end

endmodule

// File: rtl/rgb565_ypbpr_conv.sv
// RGB565 to Y/Pb/Pr DAC-code converter with a two-cycle pipeline.
// Stage 1 registers the row sums, or the chosen blank/sync level.
// Stage 2 registers the final codes. Assumes the gain is held stable while
// it should apply; a change takes effect one cycle later.
module rgb565_ypbpr_conv
    import ycc_pkg::*;
#(
    parameter int GAIN_W   = 8,
    parameter int CODE_W   = 8,
    parameter int DEF_GAIN = 60,
    parameter int GAIN_MAX = 128,
    parameter int Y_OFS    = 80,
    parameter int C_OFS    = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GAIN_W-1:0] gain,
    input  logic              pix_valid,
    input  logic [15:0]       pix_rgb,
    input  logic              lvl_sel,
    input  logic [1:0]        lvl_kind,
    output logic              out_valid,
    output logic [CODE_W-1:0] y_code,
    output logic [CODE_W-1:0] pb_code,
    output logic [CODE_W-1:0] pr_code
);

    coef_t             coef [NROW][NCOL];
    logic [CODE_W-1:0] lvl_mag;
    logic [7:0]        ch8 [NCOL];
    logic              pix_load;
    logic [CODE_W-1:0] lvl_d;
    logic              s1_valid_q;
    logic              s1_ovr_q;
    logic [CODE_W-1:0] s1_lvl_q;
    logic [CODE_W-1:0] row_code [NROW];
    logic [CODE_W-1:0] code_q   [NROW];
    logic [1:0]        age_q;

    ycc_coef_bank #(
        .GAIN_W  (GAIN_W),
        .CODE_W  (CODE_W),
        .DEF_GAIN(DEF_GAIN),
        .GAIN_MAX(GAIN_MAX)
    ) u_coef (
        .clk      (clk),
        .rst_n    (rst_n),
        .gain_i   (gain),
        .coef_o   (coef),
        .lvl_mag_o(lvl_mag)
    );

    // Widen the 5/6/5 channels to 8 bits by repeating their top bits.
    always_comb begin
        ch8[0] = {pix_rgb[15:11], pix_rgb[15:13]};
        ch8[1] = {pix_rgb[10:5],  pix_rgb[10:9]};
        ch8[2] = {pix_rgb[4:0],   pix_rgb[4:2]};
    end

    // A level request wins over a pixel; only a real pixel loads the row sums.
    always_comb begin
        pix_load = pix_valid && !lvl_sel;
    end

    // Pick the blank or sync code from the scaled magnitude.
    always_comb begin
        case (lvl_kind_e'(lvl_kind))
            LVL_SYNC_NEG: lvl_d = ~lvl_mag + CODE_W'(1);
            LVL_SYNC_POS: lvl_d = lvl_mag;
            default:      lvl_d = '0;
        endcase
    end

    genvar gr;
    generate
        for (gr = 0; gr < NROW; gr++) begin : g_row
            ycc_row_mac #(
                .CODE_W(CODE_W),
                .OFS   ((gr == 0) ? Y_OFS : C_OFS)
            ) u_row (
                .clk   (clk),
                .rst_n (rst_n),
                .load_i(pix_load),
                .ch_i  (ch8),
                .coef_i(coef[gr]),
                .code_o(row_code[gr])
            );
        end
    endgenerate

    // Stage 1 control: the valid flag, the level flag and the level code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid_q <= 1'b0;
            s1_ovr_q   <= 1'b0;
            s1_lvl_q   <= '0;
        end else begin
            s1_valid_q <= pix_valid || lvl_sel;
            s1_ovr_q   <= lvl_sel;
            if (lvl_sel) s1_lvl_q <= lvl_d;
        end
    end

    // Stage 2: register the final codes, holding them on idle cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            for (int r = 0; r < NROW; r++) code_q[r] <= '0;
        end else begin
            out_valid <= s1_valid_q;
            if (s1_valid_q) begin
                for (int r = 0; r < NROW; r++)
                    code_q[r] <= s1_ovr_q ? s1_lvl_q : row_code[r];
            end
        end
    end

    assign y_code  = code_q[0];
    assign pb_code = code_q[1];
    assign pr_code = code_q[2];

    // Counts clock edges since reset, stopping at 2; used to guard $past.
    always_ff @(posedge clk) begin
        if (!rst_n)           age_q <= 2'd0;
        else if (age_q != 2'd2) age_q <= age_q + 2'd1;
    end

    // R7
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> (out_valid == $past(pix_valid || lvl_sel, 2)));

    // R8
    level_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2 && $past(lvl_sel, 2)) |->
        (y_code == pb_code && pb_code == pr_code));

    // R9
    blank_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2 && $past(lvl_sel, 2) && $past(lvl_kind, 2) == 2'b00) |->
        (y_code == '0 && pr_code == '0));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 2'd0 && !out_valid) |->
        ($stable(y_code) && $stable(pb_code) && $stable(pr_code)));

endmodule

// File: tb/tb_rgb565_ypbpr_conv.sv
module tb_rgb565_ypbpr_conv;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] gain = 8'd128;
    logic       pix_valid = 1'b0;
    logic [15:0] pix_rgb = 16'h0000;
    logic       lvl_sel = 1'b0;
    logic [1:0] lvl_kind = 2'b00;
    logic       out_valid;
    logic [7:0] y_code, pb_code, pr_code;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rgb565_ypbpr_conv dut (
        .clk(clk), .rst_n(rst_n), .gain(gain),
        .pix_valid(pix_valid), .pix_rgb(pix_rgb),
        .lvl_sel(lvl_sel), .lvl_kind(lvl_kind),
        .out_valid(out_valid), .y_code(y_code), .pb_code(pb_code), .pr_code(pr_code)
    );

    // Stimulus table: {gain, pixel}.
    localparam int NVEC = 16;
    localparam logic [23:0] VEC [NVEC] = '{
        {8'd60,  16'hFFFF}, {8'd60,  16'h0000}, {8'd60,  16'hF800}, {8'd60,  16'h07E0},
        {8'd60,  16'h001F}, {8'd128, 16'hFFFF}, {8'd128, 16'h07FF}, {8'd128, 16'hF81F},
        {8'd100, 16'h1234}, {8'd100, 16'hABCD}, {8'd128, 16'h0400}, {8'd128, 16'h0800},
        {8'd0,   16'hFFFF}, {8'd200, 16'h07FF}, {8'd1,   16'hF800}, {8'd127, 16'h5A5A}
    };

    // Reference model, written from the requirements.
    function automatic int ref_entry(input int row, input int col, input int s);
        int m [3][3];
        int p;
        m = '{'{27, 92, 9}, '{-15, -49, 64}, '{64, -58, -6}};
        p = m[row][col] * (s > 128 ? 128 : s);
        if (p < 0) return -((-p) / 128);
        return p / 128;
    endfunction

    function automatic int ref_code(input int row, input logic [15:0] px, input int s);
        int r5, g6, b5, ch [3], acc, q, v;
        r5 = px[15:11]; g6 = px[10:5]; b5 = px[4:0];
        ch[0] = r5 * 8 + r5 / 4;
        ch[1] = g6 * 4 + g6 / 16;
        ch[2] = b5 * 8 + b5 / 4;
        acc = 0;
        for (int c = 0; c < 3; c++) acc += ref_entry(row, c, s) * ch[c];
        if (acc < 0) q = -((-acc + 127) / 128);
        else         q = acc / 128;
        v = q + (row == 0 ? 80 : 128);
        if (v < 0) v = 0;
        if (v > 255) v = 255;
        return v;
    endfunction

    function automatic int ref_level(input int kind, input int s);
        int m;
        m = (105 * (s > 128 ? 128 : s)) / 128;
        if (kind == 1) return (256 - m) % 256;
        if (kind == 2) return m;
        return 0;
    endfunction

    task automatic check(input string req, input int act, input int exp_v);
        n_chk++;
        if (act != exp_v) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    task automatic check3(input string req, input int y, input int b, input int r);
        check({req, " Y"},  int'(y_code),  y);
        check({req, " Pb"}, int'(pb_code), b);
        check({req, " Pr"}, int'(pr_code), r);
    endtask

    task automatic set_gain(input logic [7:0] g);
        @(negedge clk);
        gain = g;
        @(negedge clk);
        @(negedge clk);
    endtask

    // Present one pixel and sample the result two edges later.
    task automatic apply_pix(input logic [15:0] px);
        @(negedge clk);
        pix_valid = 1'b1; pix_rgb = px;
        @(negedge clk);
        pix_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic apply_lvl(input logic [1:0] k, input bit with_pix);
        @(negedge clk);
        lvl_sel = 1'b1; lvl_kind = k; pix_valid = with_pix; pix_rgb = 16'hFFFF;
        @(negedge clk);
        lvl_sel = 1'b0; pix_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R12: reset state, with gain already at 128.
        repeat (4) @(negedge clk);
        check("R12 reset valid", int'(out_valid), 0);
        check3("R12 reset codes", 0, 0, 0);

        // R12: first pixel after reset is converted with gain 60.
        rst_n = 1'b1; pix_valid = 1'b1; pix_rgb = 16'hF800;
        @(negedge clk);
        pix_valid = 1'b0;
        // R7: nothing valid after a single edge.
        check("R7 one edge", int'(out_valid), 0);
        @(negedge clk);
        check("R7 two edges", int'(out_valid), 1);
        check3("R12 default gain", 103, 114, 187);

        // Table walk (R2 R3 R4 R5 R6).
        for (int i = 0; i < NVEC; i++) begin
            set_gain(VEC[i][23:16]);
            apply_pix(VEC[i][15:0]);
            check("R7 table valid", int'(out_valid), 1);
            check("R2 table", int'(y_code),  ref_code(0, VEC[i][15:0], int'(VEC[i][23:16])));
            check("R3 table", int'(pb_code), ref_code(1, VEC[i][15:0], int'(VEC[i][23:16])));
            check("R4 table", int'(pr_code), ref_code(2, VEC[i][15:0], int'(VEC[i][23:16])));
        end

        // R5: truncation toward zero at gain 60 (floor would give other codes).
        set_gain(8'd60);
        apply_pix(16'hF800);
        check3("R5 trunc", 103, 114, 187);

        // R6: both clamps and floor shift at gain 128.
        set_gain(8'd128);
        apply_pix(16'h07FF);
        check3("R6 clamp", 255, 157, 0);
        // R5: gain above ceiling behaves as 128.
        set_gain(8'd200);
        apply_pix(16'h07FF);
        check3("R5 clamp gain", 255, 157, 0);
        // R5: gain 0 gives offsets only.
        set_gain(8'd0);
        apply_pix(16'hFFFF);
        check3("R5 zero gain", 80, 128, 128);

        // R1: green MSB only widens to 130, red LSB only widens to 8.
        set_gain(8'd128);
        apply_pix(16'h0400);
        check3("R1 green repl", 173, 78, 69);
        apply_pix(16'h0800);
        check3("R1 red repl", 81, 127, 132);

        // R8: levels at gain 60.
        set_gain(8'd60);
        for (int k = 0; k < 4; k++) begin
            apply_lvl(2'(k), 1'b0);
            check("R8 level valid", int'(out_valid), 1);
            check3("R8 level", ref_level(k, 60), ref_level(k, 60), ref_level(k, 60));
        end
        check("R8 neg sync code", ref_level(1, 60), 207);
        set_gain(8'd128);
        apply_lvl(2'b10, 1'b0);
        check3("R8 pos sync 128", 105, 105, 105);

        // R9: level wins over a simultaneous pixel.
        apply_lvl(2'b00, 1'b1);
        check3("R9 priority", 0, 0, 0);
        apply_lvl(2'b01, 1'b1);
        check3("R9 priority neg", 151, 151, 151);

        // R10: gain changes in the cycle of pixel B; only pixel C sees it.
        set_gain(8'd60);
        @(negedge clk);
        pix_valid = 1'b1; pix_rgb = 16'hF800;               // A
        @(negedge clk);
        gain = 8'd128;                                      // B presented with change
        @(negedge clk);
        check3("R10 pixel A", 103, 114, 187);               // C presented
        @(negedge clk);
        pix_valid = 1'b0;
        check3("R10 pixel B", 103, 114, 187);
        @(negedge clk);
        check3("R10 pixel C", 133, 98, 255);

        // R11: idle cycles hold the last codes with valid low.
        @(negedge clk);
        check("R11 idle valid", int'(out_valid), 0);
        check3("R11 idle hold", 133, 98, 255);
        repeat (3) @(negedge clk);
        check3("R11 idle hold late", 133, 98, 255);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule